// File: doc/BRIEF.md
# Sub-Word and Misaligned Access Unit

This block sits between a core's load/store port and a memory of whole 32-bit words. That memory has no byte enables. It accepts only full-word reads and writes at word addresses. The block accepts byte, halfword and word loads and stores at any byte address. It builds each one from aligned whole-word transactions:

- Narrow or misaligned loads become one or two word reads. The read data is then shifted, masked and merged.
- Narrow stores become read-modify-write sequences.
- A store that straddles a word boundary becomes two read-modify-write sequences.

A fixup-enable pin decides how a misaligned access is handled. When it is high, the hardware performs the access. When it is low, the block reports an alignment fault and touches no memory.

The core side uses a valid/ready request channel. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields steady until that edge. `busy` stays high from acceptance until the one-cycle `resp_done` pulse, which carries `resp_fault` and `resp_rdata`.

The memory side works the same way. `mem_req` is a valid signal that waits on `mem_ready`. The block holds `mem_addr`, `mem_we` and `mem_wdata` steady until the edge where `mem_ready` is high. For an accepted read, data arrives on `mem_rdata` one cycle later.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `resp_done` and `mem_req` are 0.
- R2: An aligned load (offset a multiple of its size) makes exactly one word read. It returns the addressed bytes zero-extended, with byte lane k (byte address offset k) taken from bits 8k+7:8k. Size code 0 is a byte, 1 a halfword, and 2 or 3 a word.
- R3: A misaligned load that stays inside one word (halfword at offset 1) makes one word read when fixup is enabled. It returns the shifted bytes zero-extended.
- R4: A load whose bytes cross a word boundary makes two reads, the lower word first. The upper bytes of the first word fill the low bits of the result, and the lower bytes of the next word fill the bits above them.
- R5: A store narrower than a word that does not cross a boundary makes one read and one write. Only the addressed byte lanes of that word change.
- R6: A store that crosses a word boundary makes two read-modify-write sequences: first the lower word (byte address >> 2), then the next word.
- R7: A word store at offset 0 makes one write and no read.
- R8: With fixup disabled, a misaligned access performs no memory transaction. It completes with `resp_fault`=1 and `resp_rdata`=0, and memory is unchanged.
- R9: Each accepted request gives exactly one single-cycle `resp_done`. With `mem_ready` held high, done appears 2*reads + writes clock edges after the accepting edge (0 for a fault). `req_ready` is 1 again once done has passed.
- R10: While `mem_req` is high and `mem_ready` is low, the memory request fields stay stable. Results and memory contents are the same with or without back-pressure.
- R11: An access that crosses past the last word of the address space continues at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixup_en | input | 1 | 1: handle misaligned accesses in hardware; 0: fault them |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken (unit idle) |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data, right-aligned |
| busy | output | 1 | Access in progress |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | Alignment fault, valid with done |
| resp_rdata | output | DATA_W | Load result, valid with done |
| mem_req | output | 1 | Memory transaction valid |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | DATA_W | Write word |
| mem_rdata | input | DATA_W | Read word, one cycle after an accepted read |

## Verification
A fault completes in the cycle right after acceptance. Otherwise each read costs two cycles (issue, then capture) and each write one, so with the memory always ready the bench expects done exactly 2*reads + writes edges after the accepting edge. The bench drives and samples on falling edges and counts the rising edges between acceptance and the done pulse. At the done sample it compares the load result, the fault flag, and the number of reads and writes its memory model accepted, plus the order of the write addresses. A back-pressure pass repeats the sweep with a pseudo-random `mem_ready`; there it drops the latency comparison but keeps every data and memory-image check.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ0  = 3'd1,
    ST_READ1  = 3'd2,
    ST_WRITE0 = 3'd3,
    ST_WRITE1 = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]             lo_word,
  input  logic [DATA_W-1:0]             hi_word,
  input  logic [$clog2(DATA_W/8)-1:0]   off,
  input  logic [$clog2(DATA_W/8):0]     nbytes,
  output logic [DATA_W-1:0]             result
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);

  logic [2*DATA_W-1:0] pair;
  logic [DATA_W-1:0]   shifted;

  // Two consecutive words viewed as one little-endian byte string.
  assign pair    = {hi_word, lo_word};
  assign shifted = DATA_W'(pair >> {off, 3'b000});

  // Zero-extend: keep only the lanes the access size covers.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign result[8*b +: 8] = ((OFF_W+1)'(b) < nbytes) ? shifted[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]             old_word,
  input  logic [DATA_W-1:0]             new_data,
  input  logic [$clog2(DATA_W/8)-1:0]   off,
  input  logic [$clog2(DATA_W/8):0]     nbytes,
  input  logic                          upper,
  output logic [DATA_W-1:0]             merged
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);

  logic [2*DATA_W-1:0] ins_pair;
  logic [2*NBYTES-1:0] lane_pair;
  logic [NBYTES-1:0]   lane_base;
  logic [DATA_W-1:0]   ins_half;
  logic [NBYTES-1:0]   lane_half;

  for (genvar b = 0; b < NBYTES; b++) begin : g_base
    assign lane_base[b] = ((OFF_W+1)'(b) < nbytes);
  end

  // Place the store bytes across a two-word window, then pick the half being written.
  assign ins_pair  = {{DATA_W{1'b0}}, new_data} << {off, 3'b000};
  assign lane_pair = {{NBYTES{1'b0}}, lane_base} << off;
  assign ins_half  = upper ? ins_pair[2*DATA_W-1:DATA_W] : ins_pair[DATA_W-1:0];
  assign lane_half = upper ? lane_pair[2*NBYTES-1:NBYTES] : lane_pair[NBYTES-1:0];

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = lane_half[b] ? ins_half[8*b +: 8] : old_word[8*b +: 8];
  end

endmodule

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   fixup_en,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_write,
  input  logic [1:0]                             req_size,
  input  logic [ADDR_W-1:0]                      req_addr,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_addr,
  input  logic                                   mem_ready,
  output logic                                   cap_lo,
  output logic                                   cap_hi,
  output logic                                   wr_upper,
  output logic [$clog2(DATA_W/8)-1:0]            cur_off,
  output logic [$clog2(DATA_W/8):0]              cur_nb,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   fault
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);
  localparam int WA_W   = ADDR_W - OFF_W;

  function automatic logic [OFF_W:0] bytes_of(input logic [1:0] code);
    if (code == SZ_BYTE)      return (OFF_W+1)'(1);
    else if (code == SZ_HALF) return (OFF_W+1)'(2);
    else                      return (OFF_W+1)'(NBYTES);
  endfunction

  seq_state_e          st_q, st_d;
  logic                wr_q, flt_q, span_q, full_q, rd_pend_q;
  logic [1:0]          size_q;
  logic [ADDR_W-1:0]   addr_q;

  // Decode of the incoming request.
  logic [OFF_W-1:0] in_off;
  logic [OFF_W:0]   in_nb;
  logic             in_mis, in_span, in_flt, in_full, accept;

  assign in_off  = req_addr[OFF_W-1:0];
  assign in_nb   = bytes_of(req_size);
  assign in_mis  = (in_off & OFF_W'(in_nb - 1'b1)) != '0;
  assign in_span = ({1'b0, in_off} + in_nb) > (OFF_W+1)'(NBYTES);
  assign in_flt  = in_mis && !fixup_en;
  assign in_full = req_write && (in_nb == (OFF_W+1)'(NBYTES)) && (in_off == '0);
  assign accept  = req_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d    = st_q;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    cap_lo  = 1'b0;
    cap_hi  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (in_flt)       st_d = ST_DONE;
          else if (in_full) st_d = ST_WRITE0;
          else              st_d = ST_READ0;
        end
      end
      ST_READ0: begin
        if (!rd_pend_q) mem_req = 1'b1;
        else begin
          cap_lo = 1'b1;
          if (wr_q)        st_d = ST_WRITE0;
          else if (span_q) st_d = ST_READ1;
          else             st_d = ST_DONE;
        end
      end
      ST_READ1: begin
        if (!rd_pend_q) mem_req = 1'b1;
        else begin
          cap_hi = 1'b1;
          st_d   = wr_q ? ST_WRITE1 : ST_DONE;
        end
      end
      ST_WRITE0: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) st_d = span_q ? ST_READ1 : ST_DONE;
      end
      ST_WRITE1: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rd_pend_q <= 1'b0;
      wr_q      <= 1'b0;
      flt_q     <= 1'b0;
      span_q    <= 1'b0;
      full_q    <= 1'b0;
      size_q    <= '0;
      addr_q    <= '0;
    end else begin
      st_q <= st_d;
      if (mem_req && !mem_we && mem_ready) rd_pend_q <= 1'b1;
      else if (cap_lo || cap_hi)           rd_pend_q <= 1'b0;
      if (accept) begin
        wr_q   <= req_write;
        flt_q  <= in_flt;
        span_q <= in_span;
        full_q <= in_full;
        size_q <= req_size;
        addr_q <= req_addr;
      end
    end
  end

  logic second;
  assign second    = (st_q == ST_READ1) || (st_q == ST_WRITE1);
  assign mem_addr  = addr_q[ADDR_W-1:OFF_W] + WA_W'(second);
  assign wr_upper  = (st_q == ST_WRITE1);
  assign cur_off   = addr_q[OFF_W-1:0];
  assign cur_nb    = bytes_of(size_q);
  assign busy      = (st_q != ST_IDLE);
  assign req_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign fault     = done && flt_q;

  // A faulting access must leave the memory untouched.
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flt_q) |-> !mem_req);

  // Full aligned word stores never read.
  assert_full_store_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !full_q);

  // Read data is only captured the cycle after a read was accepted.
  assert_capture_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lo || cap_hi) |-> $past(mem_req && mem_ready && !mem_we));

  // Upper-word writes belong only to stores that cross a boundary.
  assert_upper_write_spans_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && wr_upper) |-> (span_q && wr_q));

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fixup_en,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [1:0]                          req_size,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                   req_wdata,
  output logic                                busy,
  output logic                                resp_done,
  output logic                                resp_fault,
  output logic [DATA_W-1:0]                   resp_rdata,
  output logic                                mem_req,
  input  logic                                mem_ready,
  output logic                                mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  mem_addr,
  output logic [DATA_W-1:0]                   mem_wdata,
  input  logic [DATA_W-1:0]                   mem_rdata
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);

  logic              cap_lo, cap_hi, wr_upper;
  logic [OFF_W-1:0]  cur_off;
  logic [OFF_W:0]    cur_nb;
  logic [DATA_W-1:0] buf_lo, buf_hi, wdata_q, ld_result, old_word;

  lsu_align_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fixup_en  (fixup_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .wr_upper  (wr_upper),
    .cur_off   (cur_off),
    .cur_nb    (cur_nb),
    .busy      (busy),
    .done      (resp_done),
    .fault     (resp_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_lo  <= '0;
      buf_hi  <= '0;
      wdata_q <= '0;
    end else begin
      if (req_valid && req_ready) wdata_q <= req_wdata;
      if (cap_lo) buf_lo <= mem_rdata;
      if (cap_hi) buf_hi <= mem_rdata;
    end
  end

  lsu_load_align #(.DATA_W(DATA_W)) u_load (
    .lo_word (buf_lo),
    .hi_word (buf_hi),
    .off     (cur_off),
    .nbytes  (cur_nb),
    .result  (ld_result)
  );

  assign old_word = wr_upper ? buf_hi : buf_lo;

  lsu_store_merge #(.DATA_W(DATA_W)) u_store (
    .old_word (old_word),
    .new_data (wdata_q),
    .off      (cur_off),
    .nbytes   (cur_nb),
    .upper    (wr_upper),
    .merged   (mem_wdata)
  );

  assign resp_rdata = resp_fault ? '0 : ld_result;

  // Memory request fields hold while the memory stalls.
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // Completion is a single-cycle pulse.
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

endmodule

// File: tb/sim_lsu_align_unit.sv
module sim_lsu_align_unit;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int WORDS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          fixup_en, req_valid, req_ready, req_write, busy;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, resp_rdata, mem_wdata, mem_rdata;
  logic          resp_done, resp_fault, mem_req, mem_ready, mem_we;
  logic [5:0]    mem_addr;

  lsu_align_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .fixup_en(fixup_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .resp_done(resp_done), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  // Word memory model with a one-cycle read return, plus a byte reference image.
  logic [31:0] bmem [WORDS];
  logic [7:0]  rmem [256];
  logic [7:0]  lfsr;
  logic        stall_mode = 1'b0;
  int unsigned rd_total = 0, wr_total = 0;
  logic [5:0]  wlog [4];

  assign mem_ready = !stall_mode || lfsr[0];

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'h5A;
      for (int w = 0; w < WORDS; w++)
        bmem[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          bmem[mem_addr] <= mem_wdata;
          wlog[wr_total[1:0]] <= mem_addr;
          wr_total <= wr_total + 1;
        end else begin
          mem_rdata <= bmem[mem_addr];
          rd_total  <= rd_total + 1;
        end
      end
    end
  end

  int unsigned n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_mem(input string tag);
    int bad = -1;
    logic [31:0] want = '0;
    for (int w = 0; w < WORDS; w++) begin
      logic [31:0] r;
      r = {rmem[4*w+3], rmem[4*w+2], rmem[4*w+1], rmem[4*w]};
      if (bad < 0 && bmem[w] !== r) begin bad = w; want = r; end
    end
    if (bad < 0) check(tag, "memory image", 32'd0, 32'd0);
    else         check(tag, $sformatf("memory word %0d", bad), bmem[bad], want);
  endtask

  task automatic run_op(input logic wr, input logic [1:0] sz, input logic [7:0] addr,
                        input logic [31:0] data, input logic fix);
    int n, off, er, ew, lat;
    bit mis, flt, span;
    int unsigned r0, w0;
    logic [31:0] exp_ld;
    logic [5:0] wbase;
    string tag;
    n    = (sz >= 2) ? 4 : (1 << sz);
    off  = int'(addr[1:0]);
    mis  = (off % n) != 0;
    flt  = mis && !fix;
    span = (off + n) > 4;
    wbase = addr[7:2];
    if (flt) er = 0;
    else if (wr && n == 4 && off == 0) er = 0;
    else er = span ? 2 : 1;
    ew = (flt || !wr) ? 0 : (span ? 2 : 1);
    exp_ld = '0;
    for (int i = 0; i < n; i++) exp_ld |= {24'h0, rmem[8'(addr + 8'(i))]} << (8*i);
    if (!wr) tag = flt ? "R8" : (span ? "R4" : (mis ? "R3" : "R2"));
    else     tag = flt ? "R8" : (span ? "R6" : ((n == 4) ? "R7" : "R5"));
    if (span && wbase == 6'd63) tag = "R11";

    @(negedge clk);
    check("R9", "ready before request", {31'd0, req_ready}, 32'd1);
    fixup_en = fix; req_write = wr; req_size = sz; req_addr = addr; req_wdata = data;
    req_valid = 1'b1;
    r0 = rd_total; w0 = wr_total;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_done && lat < 80) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check(tag, "done seen", {31'd0, resp_done}, 32'd1);
    check(tag, "fault flag", {31'd0, resp_fault}, {31'd0, flt});
    if (!stall_mode) check("R9", "latency", lat, flt ? 0 : 2*er + ew);
    check(tag, "read count", rd_total - r0, er);
    check(tag, "write count", wr_total - w0, ew);
    if (!wr) check(tag, "load data", resp_rdata, flt ? 32'd0 : exp_ld);
    if (ew == 2) begin
      check(tag, "first write word R6", {26'd0, wlog[w0[1:0]]}, {26'd0, wbase});
      check(tag, "second write word R6", {26'd0, wlog[2'(w0 + 1)]}, {26'd0, 6'(wbase + 6'd1)});
    end
    if (wr && !flt)
      for (int i = 0; i < n; i++) rmem[8'(addr + 8'(i))] = data[8*i +: 8];
    @(negedge clk);
    check("R9", "single-cycle done", {31'd0, resp_done}, 32'd0);
    check("R9", "idle after done", {31'd0, busy}, 32'd0);
    compare_mem(stall_mode ? "R10" : tag);
  endtask

  initial begin
    int seq = 0;
    int bases [3] = '{5, 63, 20};
    fixup_en = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = '0;
    req_addr = '0; req_wdata = '0;
    for (int b = 0; b < 256; b++) rmem[b] = pat(b);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1", "busy after reset", {31'd0, busy}, 32'd0);
    check("R1", "done after reset", {31'd0, resp_done}, 32'd0);
    check("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
    compare_mem("R1");
    for (int st = 0; st < 2; st++) begin
      stall_mode = (st == 1);
      for (int fx = 0; fx < 2; fx++)
        for (int w = 0; w < 2; w++)
          for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++)
              for (int bi = 0; bi < 3; bi++) begin
                seq++;
                run_op(w[0], sz[1:0], {bases[bi][5:0], off[1:0]},
                       32'(seq) * 32'h9E3779B1, fx[0]);
              end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule